// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This unit computes a 32-bit result from two operands in one combinational step. A 3-bit opcode picks one of eight operations: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, or passing the first operand through. Along with the result it produces six condition bits: carry/borrow, signed overflow, sign, zero, a carry or borrow across the low nibble, and even parity of the low byte.

The six live flags appear on an output in the same cycle as the result. A processor datapath uses them for branching. A one-cycle write strobe copies all six into a status register that software-visible logic can read back. A synchronous reset clears that register.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (add) gives `a + b` and opcode 1 (add with carry) gives `a + b + cin`, both modulo 2^32. Flag bit 0 (carry) is the bit carried out of bit 31.
- R2: Opcode 2 (subtract) gives `a - b` and opcode 3 (subtract with borrow) gives `a - b - cin`, both modulo 2^32. Flag bit 0 is 1 exactly when the unsigned difference is negative, which is a borrow.
- R3: For opcodes 0 to 3, flag bit 1 (overflow) is 1 exactly when the true signed two's-complement result lies outside -2^31 to 2^31-1.
- R4: For every opcode, flag bit 2 (sign) equals bit 31 of the result, and flag bit 3 (zero) is 1 exactly when all 32 result bits are 0.
- R5: For opcodes 0 to 3, flag bit 4 (nibble carry) is 1 when the operation on bits 3:0 alone, including any carry-in or borrow-in, carries or borrows into bit 4.
- R6: For every opcode, flag bit 5 (parity) is 1 when result bits 7:0 hold an even number of ones. Bits 31:8 have no effect on it.
- R7: Opcodes 4, 5, 6 and 7 give `a & b`, `a | b`, `a ^ b` and `a` respectively. For these opcodes, flag bits 0, 1 and 4 are 0.
- R8: On a rising clock edge with `flag_we` high, `stat_q` takes all six live flags. With `flag_we` low, `stat_q` holds its value.
- R9: On a rising clock edge with `rst` high, `stat_q` becomes 0, whatever `flag_we` is.
- R10: For opcodes 0 and 2, `cin` has no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry-in for opcode 1, borrow-in for opcode 3 |
| op | input | 3 | Operation select, 0 to 7 |
| flag_we | input | 1 | Strobe that writes the live flags into the status register |
| result | output | 32 | Combinational result |
| flags | output | 6 | Live flags: bit 0 carry, bit 1 overflow, bit 2 sign, bit 3 zero, bit 4 nibble carry, bit 5 parity |
| stat_q | output | 6 | Registered flags, same bit order as `flags` |

## Verification
The live path has no state, so any arithmetic or flag error shows on `result` or `flags` in the same cycle as the operands that cause it. The only state is the status register. A missed capture, an unwanted capture or a reset that fails to clear shows on `stat_q` one edge later. The bench compares all three outputs against a model built on wide signed and unsigned integers in every cycle. Its vectors target the boundaries: the signed extremes, wrap-around to zero, nibble edges, and parity with a busy upper word.

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
  parameter int W     = 32,
  parameter int NIB   = 4,
  parameter int PBITS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   op,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic [5:0]   flags,
  output logic [5:0]   stat_q
);
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBB = 3'd3;
  localparam logic [2:0] OP_AND = 3'd4;
  localparam logic [2:0] OP_OR  = 3'd5;
  localparam logic [2:0] OP_XOR = 3'd6;

  logic         cx;
  logic         is_arith, is_sub;
  logic [W:0]   sum_w, dif_w;
  logic [NIB:0] sum_n, dif_n;
  logic         cf, of, sf, zf, af, pf;

  assign cx       = ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0;
  assign is_arith = ~op[2];
  assign is_sub   = op[1];

  assign sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cx};
  assign dif_w = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cx};
  assign sum_n = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cx};
  assign dif_n = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cx};

  always_comb begin
    case (op)
      OP_ADD, OP_ADC: result = sum_w[W-1:0];
      OP_SUB, OP_SBB: result = dif_w[W-1:0];
      OP_AND:         result = a & b;
      OP_OR:          result = a | b;
      OP_XOR:         result = a ^ b;
      default:        result = a;
    endcase
  end

  always_comb begin
    cf = 1'b0;
    of = 1'b0;
    af = 1'b0;
    if (is_arith) begin
      if (is_sub) begin
        cf = dif_w[W];
        af = dif_n[NIB];
        of = (a[W-1] != b[W-1]) && (result[W-1] != a[W-1]);
      end else begin
        cf = sum_w[W];
        af = sum_n[NIB];
        of = (a[W-1] == b[W-1]) && (result[W-1] != a[W-1]);
      end
    end
  end

  assign sf    = result[W-1];
  assign zf    = ~|result;
  assign pf    = ~^result[PBITS-1:0];
  assign flags = {pf, af, zf, sf, of, cf};

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= '0;
    else if (flag_we) stat_q <= flags;
  end

  p_add_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    (!op[2] && !op[1] && flags[1]) |-> (a[W-1] == b[W-1]));
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    flags[3] |-> (result == '0));
  p_logic_clear_r7: assert property (@(posedge clk) disable iff (rst)
    op[2] |-> (flags[0] == 1'b0 && flags[1] == 1'b0 && flags[4] == 1'b0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(stat_q));
  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (stat_q == $past(flags)));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (stat_q == 6'd0));
endmodule

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [2:0]  op = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags, stat_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] exp_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_flag_unit i_arith_flag_unit (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .op(op),
    .flag_we(flag_we), .result(result), .flags(flags), .stat_q(stat_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%0d op=%0d)",
               tag, act, exp, a, b, cin, op);
    end
  endtask

  task automatic model(input logic [31:0] ma, input logic [31:0] mb, input logic mc,
                       input logic [2:0] mo, output logic [31:0] r, output logic [5:0] f);
    longint ua, ub, sa, sb, u, s, c, nib;
    logic cf, of, af;
    ua = longint'(ma); ub = longint'(mb);
    sa = longint'($signed(ma)); sb = longint'($signed(mb));
    c  = (mo == 3'd1 || mo == 3'd3) ? longint'(mc) : 0;
    cf = 0; of = 0; af = 0;
    case (mo)
      3'd0, 3'd1: begin
        u = ua + ub + c; s = sa + sb + c;
        nib = (ua % 16) + (ub % 16) + c;
        cf = (u >= 64'sd4294967296); af = (nib >= 16);
        of = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        r = u[31:0];
      end
      3'd2, 3'd3: begin
        u = ua - ub - c; s = sa - sb - c;
        nib = (ua % 16) - (ub % 16) - c;
        cf = (u < 0); af = (nib < 0);
        of = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        r = u[31:0];
      end
      3'd4: r = ma & mb;
      3'd5: r = ma | mb;
      3'd6: r = ma ^ mb;
      default: r = ma;
    endcase
    f = {($countones(r[7:0]) % 2 == 0), af, (r == 0), r[31], of, cf};
  endtask

  task automatic apply(input logic [31:0] va, input logic [31:0] vb, input logic vc,
                       input logic [2:0] vo, input logic we, input string note);
    logic [31:0] er;
    logic [5:0]  ef;
    string grp;
    @(negedge clk);
    a = va; b = vb; cin = vc; op = vo; flag_we = we;
    model(va, vb, vc, vo, er, ef);
    grp = (vo <= 3'd1) ? "R1" : (vo <= 3'd3) ? "R2" : "R7";
    #1;
    check({grp, " result ", note}, result, er);
    check({grp, " carry ", note}, {31'd0, flags[0]}, {31'd0, ef[0]});
    check({(vo[2] ? "R7" : "R3"), " overflow ", note}, {31'd0, flags[1]}, {31'd0, ef[1]});
    check({"R4 sign ", note}, {31'd0, flags[2]}, {31'd0, ef[2]});
    check({"R4 zero ", note}, {31'd0, flags[3]}, {31'd0, ef[3]});
    check({(vo[2] ? "R7" : "R5"), " nibble ", note}, {31'd0, flags[4]}, {31'd0, ef[4]});
    check({"R6 parity ", note}, {31'd0, flags[5]}, {31'd0, ef[5]});
    @(posedge clk);
    if (rst) exp_stat = '0;
    else if (we) exp_stat = ef;
    #1;
    check(rst ? "R9 stat reset" : "R8 stat", {26'd0, stat_q}, {26'd0, exp_stat});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state, flag_we high must not capture
    apply(32'hFFFF_FFFF, 32'h1, 1'b0, 3'd0, 1'b1, "reset");
    @(negedge clk); #1;
    check("R9 stat after reset", {26'd0, stat_q}, 32'd0);
    rst = 1'b0;
    // R1
    apply(32'hFFFF_FFFF, 32'h1, 1'b0, 3'd0, 1'b1, "wrap to zero");
    apply(32'h1234_5678, 32'h1111_1111, 1'b1, 3'd1, 1'b1, "adc");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 3'd1, 1'b0, "adc max");
    // R3
    apply(32'h7FFF_FFFF, 32'h1, 1'b0, 3'd0, 1'b1, "pos overflow");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, 3'd0, 1'b1, "neg overflow");
    apply(32'h8000_0000, 32'h1, 1'b0, 3'd2, 1'b1, "sub overflow");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd2, 1'b1, "sub overflow pos");
    // R2
    apply(32'h0, 32'h1, 1'b0, 3'd2, 1'b1, "borrow");
    apply(32'h5, 32'h5, 1'b1, 3'd3, 1'b1, "sbb borrow");
    apply(32'h5, 32'h5, 1'b0, 3'd3, 1'b0, "sbb equal");
    // R5
    apply(32'h0000_000F, 32'h1, 1'b0, 3'd0, 1'b1, "nibble carry");
    apply(32'h0000_0010, 32'h1, 1'b0, 3'd2, 1'b1, "nibble borrow");
    apply(32'h0000_0007, 32'h8, 1'b1, 3'd1, 1'b1, "nibble carry via cin");
    // R6: busy upper bits, low byte parity varies
    apply(32'hFFFF_FF00, 32'h0000_0003, 1'b0, 3'd5, 1'b1, "parity even");
    apply(32'hFFFF_FF00, 32'h0000_0001, 1'b0, 3'd5, 1'b1, "parity odd");
    // R7
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 1'b1, 3'd4, 1'b1, "and");
    apply(32'hF0F0_F0F0, 32'hF0F0_F0F0, 1'b1, 3'd6, 1'b1, "xor zero");
    apply(32'h8000_0001, 32'h1234_5678, 1'b1, 3'd7, 1'b1, "pass");
    // R10: cin ignored by plain add and subtract
    apply(32'h0000_000F, 32'hFFFF_FFF0, 1'b1, 3'd0, 1'b1, "R10 add cin");
    apply(32'h0000_0010, 32'h0000_0010, 1'b1, 3'd2, 1'b1, "R10 sub cin");
    // R8: hold with strobe low across several different operations
    apply(32'h0, 32'h0, 1'b0, 3'd5, 1'b1, "capture zero");
    apply(32'hFFFF_FFFF, 32'h1, 1'b0, 3'd0, 1'b0, "hold 1");
    apply(32'h8000_0000, 32'h1, 1'b0, 3'd2, 1'b0, "hold 2");
    // R9: mid-run reset
    rst = 1'b1;
    apply(32'h1, 32'h2, 1'b0, 3'd0, 1'b1, "mid reset");
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      apply($urandom, $urandom, 1'($urandom), 3'($urandom), 1'($urandom), "sweep");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule